// File: doc/BRIEF.md
# Multicycle Shared-ALU Datapath

This block is the datapath of a small 32-bit load/store processor that spends several clock cycles on each instruction. One ALU and one unified memory port are reused across the cycles of an instruction. The ALU increments the program counter, forms the branch target, computes the memory address and produces the arithmetic result, each in its own cycle. Every value that must survive a cycle boundary is parked in a dedicated internal register: instruction, first operand, second operand, ALU result and memory data.

The datapath makes no decisions of its own. An external sequencer drives the write enables, mux selects, ALU operation and memory strobes each cycle. The datapath returns the opcode field, the function field and an operand-equality flag so the sequencer can pick its next step. The sequence covers loads, stores, register-to-register arithmetic and branch-if-equal. A separate image-write port places words into the memory so that a program and its data can be set up.

Instruction fields: opcode is bits 31:26, first source index 25:21, second source index 20:16, destination index 15:11, function code 5:0, immediate 15:0.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter (`pc_q`) to zero on the next clock edge.
- R2: In a fetch cycle (`mem_sel`=0, `mem_rd`=1, `ir_we`=1, `alu_a_sel`=0, `alu_b_sel`=1, `alu_op`=0, `pc_we`=1, `pc_src`=0), `mem_rdata` shows the word at `pc_q[N:2]`, the instruction register loads it, and `pc_q` becomes PC+4. Afterwards `opcode` shows IR[31:26] and `funct` shows IR[5:0].
- R3: With `ab_we`=1 the first operand register loads register IR[25:21] and the second loads register IR[20:16]. From the next cycle `a_eq_b` is 1 exactly when the two are equal. With `alu_a_sel`=0 and `alu_b_sel`=3, `alu_y` is PC plus the sign-extended IR[15:0] shifted left by two.
- R4: `alu_op` encodings are 0 add, 1 subtract, 2 AND, 3 OR and 4 signed set-less-than (result 1 or 0). Codes 5 to 7 give zero. With `alu_a_sel`=1 and `alu_b_sel`=0 the ALU combines the two operand registers.
- R5: With `alu_a_sel`=1 and `alu_b_sel`=2, `alu_y` is the first operand plus the sign-extended IR[15:0], including negative offsets.
- R6: With `rf_we`=1, `rf_dst`=1 and `rf_src`=0, the ALU result register is written into register IR[15:11].
- R7: With `mem_sel`=1, `mem_rd`=1 and `mdr_we`=1, the word at the ALU result register's address bits [N:2] loads the memory data register. A following cycle with `rf_we`=1, `rf_dst`=0 and `rf_src`=1 writes it into register IR[20:16].
- R8: With `mem_sel`=1 and `mem_wr`=1, the second operand register is written to memory at the ALU result register's address bits [N:2].
- R9: With `br_en`=1 and `pc_we`=0, the program counter loads the ALU result register when the operands are equal and holds otherwise.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: `mem_rdata` is zero while `mem_rd` is 0. An `img_we` cycle writes `img_data` to word `img_addr`.
- R12: With `pc_we`=0 and no taken branch, the program counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| img_we | input | 1 | Image write strobe into memory |
| img_addr | input | log2(MEM_WORDS) | Image write word index |
| img_data | input | 32 | Image write data |
| pc_we | input | 1 | Unconditional program counter write |
| pc_src | input | 1 | PC source: 0 ALU output, 1 ALU result register |
| br_en | input | 1 | Branch cycle: load PC from ALU result register if operands equal |
| ir_we | input | 1 | Instruction register load |
| ab_we | input | 1 | Operand registers load from register file |
| aluout_we | input | 1 | ALU result register load |
| mdr_we | input | 1 | Memory data register load |
| rf_we | input | 1 | Register file write |
| rf_dst | input | 1 | Write index: 0 IR[20:16], 1 IR[15:11] |
| rf_src | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| mem_sel | input | 1 | Memory address: 0 PC, 1 ALU result register |
| alu_a_sel | input | 1 | ALU A input: 0 PC, 1 first operand register |
| alu_b_sel | input | 2 | ALU B input: 0 second operand, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| alu_op | input | 3 | ALU operation code |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| a_eq_b | output | 1 | Operand registers are equal |
| pc_q | output | 32 | Program counter |
| alu_y | output | 32 | Combinational ALU output |
| mem_rdata | output | 32 | Memory read data |

## Verification
The bench builds the datapath with a 64-word memory. This lets a program area, a data area and backward wrap branches to address zero coexist, and it reaches every word the sequence touches. In that small memory the bench sweeps every ALU code over all pairs of eight loaded operands: zero, one, all ones, the most negative value, the most positive value, an equal pair and mixed patterns. This exposes sign, carry and equality corners of subtract and set-less-than. Loads with a negative offset from a base register, stores read back through loads, branches taken and not taken, and writes aimed at register 0 are all checked against a bench model of registers and memory.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN  = 32;
  localparam int NREG  = 32;
  localparam int RIDX  = 5;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    BSEL_REG   = 2'd0,
    BSEL_FOUR  = 2'd1,
    BSEL_IMM   = 2'd2,
    BSEL_IMMSH = 2'd3
  } bsel_e;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input logic [2:0] op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic [RIDX-1:0] ra1,
  input  logic [RIDX-1:0] ra2,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [XLEN-1:0] wd,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);
  logic [XLEN-1:0] regs [1:NREG-1];

  always_ff @(posedge clk) begin
    for (int i = 1; i < NREG; i++) begin
      if (we && (wa == RIDX'(i))) regs[i] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_mem.sv
module mc_mem
  import mc_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            img_we,
  input  logic [AW-1:0]   img_addr,
  input  logic [XLEN-1:0] img_data,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (img_we)  store[img_addr] <= img_data;
    else if (wr) store[addr]     <= wdata;
  end

  assign rdata = rd ? store[addr] : '0;
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  localparam int MAW      = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             img_we,
  input  logic [MAW-1:0]   img_addr,
  input  logic [31:0]      img_data,
  input  logic             pc_we,
  input  logic             pc_src,
  input  logic             br_en,
  input  logic             ir_we,
  input  logic             ab_we,
  input  logic             aluout_we,
  input  logic             mdr_we,
  input  logic             rf_we,
  input  logic             rf_dst,
  input  logic             rf_src,
  input  logic             mem_rd,
  input  logic             mem_wr,
  input  logic             mem_sel,
  input  logic             alu_a_sel,
  input  logic [1:0]       alu_b_sel,
  input  logic [2:0]       alu_op,
  output logic [5:0]       opcode,
  output logic [5:0]       funct,
  output logic             a_eq_b,
  output logic [31:0]      pc_q,
  output logic [31:0]      alu_y,
  output logic [31:0]      mem_rdata
);
  // cycle-boundary registers
  logic [XLEN-1:0] ir_q, a_q, b_q, aluout_q, mdr_q;

  // named internal events
  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx;
  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] alu_a, alu_b;
  logic [XLEN-1:0] rf_rd1, rf_rd2;
  logic [RIDX-1:0] rf_wr_addr;
  logic [XLEN-1:0] rf_wr_data;
  logic [MAW-1:0]  mem_word;
  logic            br_take;

  assign opcode   = ir_q[31:26];
  assign funct    = ir_q[5:0];
  assign rs_idx   = ir_q[25:21];
  assign rt_idx   = ir_q[20:16];
  assign rd_idx   = ir_q[15:11];
  assign imm_sext = sext16(ir_q[15:0]);

  assign a_eq_b  = (a_q == b_q);
  assign br_take = br_en && a_eq_b;

  // ALU operand muxes
  assign alu_a = alu_a_sel ? a_q : pc_q;
  always_comb begin
    case (bsel_e'(alu_b_sel))
      BSEL_REG:   alu_b = b_q;
      BSEL_FOUR:  alu_b = XLEN'(4);
      BSEL_IMM:   alu_b = imm_sext;
      default:    alu_b = {imm_sext[XLEN-3:0], 2'b00};
    endcase
  end

  mc_alu u_alu (
    .op (alu_op),
    .a  (alu_a),
    .b  (alu_b),
    .y  (alu_y)
  );

  // register file write path
  assign rf_wr_addr = rf_dst ? rd_idx : rt_idx;
  assign rf_wr_data = rf_src ? mdr_q : aluout_q;

  mc_regfile u_rf (
    .clk (clk),
    .ra1 (rs_idx),
    .ra2 (rt_idx),
    .we  (rf_we),
    .wa  (rf_wr_addr),
    .wd  (rf_wr_data),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2)
  );

  // unified memory, word-addressed
  assign mem_word = mem_sel ? aluout_q[MAW+1:2] : pc_q[MAW+1:2];

  mc_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk      (clk),
    .img_we   (img_we),
    .img_addr (img_addr),
    .img_data (img_data),
    .wr       (mem_wr),
    .rd       (mem_rd),
    .addr     (mem_word),
    .wdata    (b_q),
    .rdata    (mem_rdata)
  );

  // architectural PC
  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (pc_we)   pc_q <= pc_src ? aluout_q : alu_y;
    else if (br_take) pc_q <= aluout_q;
  end

  // internal latches, no reset needed
  always_ff @(posedge clk) begin
    if (ir_we)     ir_q     <= mem_rdata;
    if (ab_we)     a_q      <= rf_rd1;
    if (ab_we)     b_q      <= rf_rd2;
    if (aluout_we) aluout_q <= alu_y;
    if (mdr_we)    mdr_q    <= mem_rdata;
  end
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk,
  input logic        rst,
  input logic        pc_we,
  input logic        pc_src,
  input logic        br_en,
  input logic        ir_we,
  input logic        ab_we,
  input logic        mdr_we,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        a_eq_b,
  input logic [31:0] pc_q,
  input logic [31:0] alu_y,
  input logic [31:0] mem_rdata,
  input logic [31:0] ir_q,
  input logic [31:0] a_q,
  input logic [31:0] aluout_q,
  input logic [31:0] mdr_q,
  input logic [4:0]  rs_idx
);
  p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc_q == 32'd0));

  p_ir_load_r2: assert property (@(posedge clk) disable iff (rst)
    ir_we |=> (ir_q == $past(mem_rdata)));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (pc_we && !pc_src) |=> (pc_q == $past(alu_y)));

  p_mdr_load_r7: assert property (@(posedge clk) disable iff (rst)
    mdr_we |=> (mdr_q == $past(mem_rdata)));

  p_mem_strobes_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_branch_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (!pc_we && br_en && a_eq_b) |=> (pc_q == $past(aluout_q)));

  p_zero_reg_r10: assert property (@(posedge clk) disable iff (rst)
    (ab_we && rs_idx == 5'd0) |=> (a_q == 32'd0));

  p_pc_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!pc_we && !(br_en && a_eq_b)) |=> $stable(pc_q));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pc_we     (pc_we),
  .pc_src    (pc_src),
  .br_en     (br_en),
  .ir_we     (ir_we),
  .ab_we     (ab_we),
  .mdr_we    (mdr_we),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .a_eq_b    (a_eq_b),
  .pc_q      (pc_q),
  .alu_y     (alu_y),
  .mem_rdata (mem_rdata),
  .ir_q      (ir_q),
  .a_q       (a_q),
  .aluout_q  (aluout_q),
  .mdr_q     (mdr_q),
  .rs_idx    (rs_idx)
);

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
  localparam int WORDS = 64;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic img_we; logic [AW-1:0] img_addr; logic [31:0] img_data;
  logic pc_we, pc_src, br_en, ir_we, ab_we, aluout_we, mdr_we;
  logic rf_we, rf_dst, rf_src, mem_rd, mem_wr, mem_sel, alu_a_sel;
  logic [1:0] alu_b_sel; logic [2:0] alu_op;
  logic [5:0] opcode, funct; logic a_eq_b;
  logic [31:0] pc_q, alu_y, mem_rdata;

  always #4 clk = ~clk;

  mc_datapath #(.MEM_WORDS(WORDS)) uut (
    .clk(clk), .rst(rst), .img_we(img_we), .img_addr(img_addr), .img_data(img_data),
    .pc_we(pc_we), .pc_src(pc_src), .br_en(br_en), .ir_we(ir_we), .ab_we(ab_we),
    .aluout_we(aluout_we), .mdr_we(mdr_we), .rf_we(rf_we), .rf_dst(rf_dst),
    .rf_src(rf_src), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_sel(mem_sel),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .opcode(opcode), .funct(funct), .a_eq_b(a_eq_b), .pc_q(pc_q),
    .alu_y(alu_y), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model
  logic [31:0] rf_m [32];
  logic [31:0] mem_m [WORDS];
  logic [31:0] pc_m, ir_m, a_m, b_m, aluout_m, mdr_m;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ext(input logic [15:0] v);
    logic [31:0] r;
    r = {16'h0000, v};
    if (v[15]) r = r | 32'hFFFF_0000;
    return r;
  endfunction

  function automatic logic [31:0] ref_alu(input int op, input logic [31:0] a, input logic [31:0] b);
    logic signed [32:0] sa, sb;
    sa = {a[31], a}; sb = {b[31], b};
    if (op == 0) return a + b;
    if (op == 1) return a + (~b) + 32'd1;
    if (op == 2) return ~(~a | ~b);
    if (op == 3) return ~(~a & ~b);
    if (op == 4) return (sa - sb < 0) ? 32'd1 : 32'd0;
    return 32'd0;
  endfunction

  task automatic idle();
    img_we = 0; img_addr = '0; img_data = '0;
    pc_we = 0; pc_src = 0; br_en = 0; ir_we = 0; ab_we = 0; aluout_we = 0;
    mdr_we = 0; rf_we = 0; rf_dst = 0; rf_src = 0; mem_rd = 0; mem_wr = 0;
    mem_sel = 0; alu_a_sel = 0; alu_b_sel = 2'd0; alu_op = 3'd0;
  endtask

  task automatic img(input int idx, input logic [31:0] w);
    @(negedge clk); idle();
    img_we = 1; img_addr = AW'(idx); img_data = w;
    mem_m[idx] = w;
  endtask

  task automatic fetch(input logic [31:0] instr);
    img(int'(pc_m[AW+1:2]), instr);
    @(negedge clk); idle();
    mem_sel = 0; mem_rd = 1; ir_we = 1; alu_a_sel = 0; alu_b_sel = 2'd1;
    alu_op = 3'd0; pc_we = 1; pc_src = 0;
    #1;
    chk(mem_rdata == instr, "R2 fetch read", mem_rdata, instr);
    chk(alu_y == pc_m + 32'd4, "R2 pc+4", alu_y, pc_m + 32'd4);
    ir_m = instr; pc_m = pc_m + 32'd4;
  endtask

  task automatic decode();
    logic [31:0] tgt;
    @(negedge clk); idle();
    ab_we = 1; aluout_we = 1; alu_a_sel = 0; alu_b_sel = 2'd3; alu_op = 3'd0;
    #1;
    chk(pc_q == pc_m, "R2 pc after fetch", pc_q, pc_m);
    chk(opcode == ir_m[31:26] && funct == ir_m[5:0], "R2 fields",
        {20'd0, opcode, funct}, {20'd0, ir_m[31:26], ir_m[5:0]});
    tgt = pc_m + ext(ir_m[15:0]) * 32'd4;
    chk(alu_y == tgt, "R3 branch target", alu_y, tgt);
    a_m = rf_m[ir_m[25:21]]; b_m = rf_m[ir_m[20:16]]; aluout_m = tgt;
  endtask

  task automatic run_beq(input int rs, input int rt, input logic [15:0] off);
    fetch({6'h04, 5'(rs), 5'(rt), off});
    decode();
    @(negedge clk); idle();
    br_en = 1;
    #1;
    chk(a_eq_b == (a_m == b_m), "R3 equality flag", {31'd0, a_eq_b}, {31'd0, (a_m == b_m)});
    if (a_m == b_m) pc_m = aluout_m;
    @(negedge clk); idle();
    #1;
    chk(pc_q == pc_m, "R9 R12 pc after branch", pc_q, pc_m);
  endtask

  task automatic wrap();
    logic [31:0] nxt;
    if (pc_m[AW+1:2] >= 6'd40) begin
      nxt = pc_m + 32'd4;
      run_beq(0, 0, 16'(-(nxt >> 2)));
      chk(pc_q == 32'd0, "R9 wrap to zero", pc_q, 32'd0);
    end
  endtask

  task automatic run_r(input int rs, input int rt, input int rd, input int op);
    logic [31:0] e;
    wrap();
    fetch({6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(32 + op)});
    decode();
    @(negedge clk); idle();
    alu_a_sel = 1; alu_b_sel = 2'd0; alu_op = 3'(op); aluout_we = 1;
    #1;
    e = ref_alu(op, a_m, b_m);
    chk(a_eq_b == (a_m == b_m), "R3 equality flag", {31'd0, a_eq_b}, {31'd0, (a_m == b_m)});
    chk(alu_y == e, $sformatf("R4 op%0d", op), alu_y, e);
    aluout_m = e;
    @(negedge clk); idle();
    rf_we = 1; rf_dst = 1; rf_src = 0;
    if (rd != 0) rf_m[rd] = aluout_m;
  endtask

  // reads register r out through the ALU (OR with r0, result into r0)
  task automatic peek(input int r, input string tag);
    wrap();
    fetch({6'h00, 5'(r), 5'd0, 5'd0, 5'd0, 6'h25});
    decode();
    @(negedge clk); idle();
    alu_a_sel = 1; alu_b_sel = 2'd0; alu_op = 3'd3; aluout_we = 1;
    #1;
    chk(alu_y == rf_m[r], tag, alu_y, rf_m[r]);
    @(negedge clk); idle();
    rf_we = 1; rf_dst = 1; rf_src = 0;
  endtask

  task automatic addr_step();
    logic [31:0] e;
    @(negedge clk); idle();
    alu_a_sel = 1; alu_b_sel = 2'd2; alu_op = 3'd0; aluout_we = 1;
    #1;
    e = a_m + ext(ir_m[15:0]);
    chk(alu_y == e, "R5 address", alu_y, e);
    aluout_m = e;
  endtask

  task automatic run_lw(input int rt, input int base, input logic [15:0] off);
    wrap();
    fetch({6'h23, 5'(base), 5'(rt), off});
    decode();
    addr_step();
    @(negedge clk); idle();
    mem_sel = 1; mem_rd = 1; mdr_we = 1;
    #1;
    mdr_m = mem_m[aluout_m[AW+1:2]];
    chk(mem_rdata == mdr_m, "R7 load data", mem_rdata, mdr_m);
    @(negedge clk); idle();
    rf_we = 1; rf_dst = 0; rf_src = 1;
    if (rt != 0) rf_m[rt] = mdr_m;
  endtask

  task automatic run_sw(input int rt, input int base, input logic [15:0] off);
    wrap();
    fetch({6'h2B, 5'(base), 5'(rt), off});
    decode();
    addr_step();
    @(negedge clk); idle();
    mem_sel = 1; mem_wr = 1;
    mem_m[aluout_m[AW+1:2]] = b_m;
  endtask

  function automatic logic [31:0] dval(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h1234_5678;
      6: return 32'h1234_5678;
      7: return 32'hA5A5_0F0F;
      15: return 32'd320;
      default: return (32'h0101_0103 * k) ^ 32'h5500_00AA;
    endcase
  endfunction

  initial begin
    idle();
    pc_m = 0;
    for (int i = 0; i < 32; i++) rf_m[i] = 32'd0;
    for (int i = 0; i < WORDS; i++) mem_m[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(pc_q == 32'd0, "R1 reset pc", pc_q, 32'd0);

    // data region at words 48..63; R11 image port and idle read bus
    for (int k = 0; k < 16; k++) img(48 + k, dval(k));
    @(negedge clk); idle();
    mem_sel = 1;
    #1;
    chk(mem_rdata == 32'd0, "R11 read bus idle", mem_rdata, 32'd0);

    // R7 loads of operands into r1..r8 and base r9
    for (int k = 0; k < 8; k++) begin
      run_lw(k + 1, 0, 16'(192 + 4 * k));
      peek(k + 1, "R7 loaded register");
    end
    run_lw(9, 0, 16'(252));
    // R5 negative offset from base 320 -> byte 200 (word 50)
    run_lw(10, 9, 16'hFF88);
    peek(10, "R5 R7 negative offset load");

    // R4 R6 sweep every ALU code over all operand pairs
    for (int op = 0; op < 8; op++)
      for (int i = 1; i <= 8; i++)
        for (int j = 1; j <= 8; j++) begin
          run_r(i, j, 20, op);
          peek(20, "R6 destination register");
        end

    // R10 writes to register 0 are dropped
    run_r(3, 4, 0, 0);
    peek(0, "R10 zero register");
    run_lw(0, 0, 16'(196));
    peek(0, "R10 zero register after load");

    // R8 store and read back
    run_sw(8, 0, 16'(224));
    run_lw(21, 0, 16'(224));
    peek(21, "R8 stored word");
    run_sw(5, 9, 16'hFFA0);
    run_lw(22, 0, 16'(224));
    peek(22, "R8 store via base");

    // R9 branches taken and not taken
    wrap();
    run_beq(6, 7, 16'd3);
    wrap();
    run_beq(1, 2, 16'd3);
    wrap();
    run_beq(3, 4, 16'hFFFF);

    // R1 reset mid-run
    @(negedge clk); idle();
    rst = 1;
    @(negedge clk); rst = 0;
    #1;
    pc_m = 0;
    chk(pc_q == 32'd0, "R1 second reset", pc_q, 32'd0);
    peek(5, "R2 fetch after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule